// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup and Oldest-First Select

The block parks renamed micro-ops until both of their source physical registers exist. Each parked micro-op keeps a source tag and a ready flag for each of its two sources. A single result bus announces destination tags as producers finish execution, and any parked source whose tag matches becomes ready. Every cycle the block offers exactly one micro-op, the oldest one whose sources are all ready, to a single execution port. The port accepts it with a grant, and the accepted entry is freed at that clock edge.

Micro-ops enter through a valid/ready dispatch stream. `disp_ready` is low when all slots are occupied or a flush is in progress, and a micro-op is taken only on a cycle where `disp_valid` and `disp_ready` are both high. The issue side is also a valid/ready stream. `iss_ready` acts as the execution port's grant. While it is low, the offered micro-op stays in the queue. The offer can only change when a broadcast wakes an older entry.

Each micro-op carries a 6-bit sequence number that rises by one per dispatch. All age decisions use modular comparison, so they stay correct across wrap-around. A flush request removes every entry that is younger than a given sequence number.

Top module: `rs_wakeup_select`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is 0 and `disp_ready` is 1.
- R2: A micro-op dispatched with both source ready flags set becomes eligible in the cycle after its dispatch edge, and not in the dispatch cycle itself.
- R3: A broadcast with `bcast_valid` high whose `bcast_tag` equals a waiting source tag marks that source ready. An entry whose last source is woken this way can be offered on `iss_valid` in the cycle after the broadcast cycle. A broadcast whose tag matches none of an entry's sources leaves that entry unchanged.
- R4: A micro-op dispatched in the same cycle as a broadcast whose tag matches one of its waiting sources captures that wakeup.
- R5: Among ready entries the one with the oldest sequence number is offered. Sequence a is younger than b when the 6-bit difference a-b is nonzero and below 32. This rule holds across wrap-around, provided in-flight numbers span less than 32.
- R6: A micro-op leaves the queue at the edge where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low and no broadcast occurs, the same micro-op stays offered.
- R7: The queue holds 8 micro-ops. When all 8 slots are occupied, `disp_ready` is 0 and a dispatch attempt is dropped without changing the contents.
- R8: In a cycle with `flush_valid` high, every entry younger than `flush_seq` (by the R5 rule) is removed, while older entries and the entry equal to `flush_seq` remain. During that cycle `disp_ready` and `iss_valid` are both 0.
- R9: An entry with exactly one of its two sources ready is never offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch stream valid |
| disp_ready | output | 1 | Dispatch stream ready (free slot and no flush) |
| disp_payload | input | 16 | Opaque micro-op payload |
| disp_dst_tag | input | 6 | Destination physical tag |
| disp_src0_tag | input | 6 | First source physical tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1_tag | input | 6 | Second source physical tag |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_seq | input | 6 | Dispatch sequence number (age) |
| bcast_valid | input | 1 | Result bus valid |
| bcast_tag | input | 6 | Tag of a completed destination |
| flush_valid | input | 1 | Flush request |
| flush_seq | input | 6 | Entries younger than this are removed |
| iss_valid | output | 1 | Issue stream valid |
| iss_ready | input | 1 | Grant from the execution port |
| iss_payload | output | 16 | Payload of the offered micro-op |
| iss_dst_tag | output | 6 | Destination tag of the offered micro-op |
| iss_src0_tag | output | 6 | First source tag of the offered micro-op |
| iss_src1_tag | output | 6 | Second source tag of the offered micro-op |
| iss_seq | output | 6 | Sequence number of the offered micro-op |

## Verification
The bench targets four groups of failures:

- **Age ordering.** Sequence numbers wrap from 63 to 0, and freed low slots are refilled by younger micro-ops. A select that followed slot index or unsigned comparison would issue a younger micro-op ahead of an older one.
- **Wakeup capture.** Broadcasts arrive in the dispatch cycle of a micro-op. A design that missed them would strand that micro-op forever. Broadcasts with non-matching tags, and entries with only one source woken, are also used; a design that woke on any broadcast or on one source would issue too early.
- **Full queue and flush.** A dispatch is attempted while the queue is full; a design that overwrote a slot would lose a micro-op. Flushes land among mixed ages; a design with an off-by-one boundary would drop the boundary entry or keep a younger one.
- **Back-pressure.** Long runs with `iss_ready` low check that no entry disappears unless it was granted.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
  localparam int RS_TAG_W = 6;
  localparam int RS_SEQ_W = 6;
  localparam int RS_PAY_W = 16;
  localparam int RS_NSRC  = 2;

  typedef struct packed {
    logic [RS_PAY_W-1:0]               payload;
    logic [RS_TAG_W-1:0]               dst;
    logic [RS_SEQ_W-1:0]               seq;
    logic [RS_NSRC-1:0][RS_TAG_W-1:0]  src_tag;
    logic [RS_NSRC-1:0]                src_rdy;
  } rs_uop_t;

  // a is strictly younger than b under modular sequence arithmetic
  function automatic logic seq_younger(input logic [RS_SEQ_W-1:0] a,
                                       input logic [RS_SEQ_W-1:0] b);
    logic [RS_SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[RS_SEQ_W-1];
  endfunction
endpackage

// File: rtl/rs_free_pick.sv
`timescale 1ns/1ps
module rs_free_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] pick_oh,
  output logic         any_free
);
  always_comb begin
    logic found;
    found   = 1'b0;
    pick_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i] && !found) begin
        pick_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign any_free = ~&busy;
endmodule

// File: rtl/rs_entry.sv
`timescale 1ns/1ps
module rs_entry
  import rs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc,
  input  rs_uop_t             din,
  input  logic                bcast_valid,
  input  logic [RS_TAG_W-1:0] bcast_tag,
  input  logic                issue_kill,
  input  logic                flush_valid,
  input  logic [RS_SEQ_W-1:0] flush_seq,
  output logic                valid,
  output logic                ready,
  output rs_uop_t             dout
);
  logic                valid_q;
  rs_uop_t             ent_q;
  logic [RS_NSRC-1:0]  hit_new;
  logic [RS_NSRC-1:0]  hit_old;
  logic                flush_hit;

  generate
    for (genvar s = 0; s < RS_NSRC; s++) begin : g_src
      assign hit_new[s] = bcast_valid && (din.src_tag[s]   == bcast_tag);
      assign hit_old[s] = bcast_valid && (ent_q.src_tag[s] == bcast_tag);
    end
  endgenerate

  assign flush_hit = flush_valid && seq_younger(ent_q.seq, flush_seq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ent_q   <= '0;
    end else if (alloc) begin
      valid_q       <= 1'b1;
      ent_q         <= din;
      ent_q.src_rdy <= din.src_rdy | hit_new;
    end else begin
      if (issue_kill || flush_hit) valid_q <= 1'b0;
      ent_q.src_rdy <= ent_q.src_rdy | hit_old;
    end
  end

  assign valid = valid_q;
  assign ready = valid_q && (&ent_q.src_rdy);
  assign dout  = ent_q;

  // Readiness of a resident entry only appears after a result broadcast
  AST_WAKE_NEEDS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(valid_q) && !$past(alloc) && $rose(ready)) |-> $past(bcast_valid)); // R3

  // A granted entry is gone after the edge
  AST_ISSUED_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    issue_kill |=> !valid_q); // R6
endmodule

// File: rtl/rs_age_matrix.sv
`timescale 1ns/1ps
module rs_age_matrix #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // older_q[i][j] set: slot i holds an older micro-op than slot j
  logic [N-1:0] older_q [N];
  logic [N-1:0] blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (i != j) begin
            if (alloc_oh[j])      older_q[i][j] <= 1'b1;
            else if (alloc_oh[i]) older_q[i][j] <= 1'b0;
          end
        end
      end
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_sel
      always_comb begin
        blocked[i] = 1'b0;
        for (int j = 0; j < N; j++) begin
          if (j != i && req[j] && older_q[j][i]) blocked[i] = 1'b1;
        end
      end
      assign gnt[i] = req[i] && !blocked[i];
    end
  endgenerate

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R5

  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt)); // R5
endmodule

// File: rtl/rs_wakeup_select.sv
`timescale 1ns/1ps
module rs_wakeup_select
  import rs_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                disp_valid,
  output logic                disp_ready,
  input  logic [RS_PAY_W-1:0] disp_payload,
  input  logic [RS_TAG_W-1:0] disp_dst_tag,
  input  logic [RS_TAG_W-1:0] disp_src0_tag,
  input  logic                disp_src0_rdy,
  input  logic [RS_TAG_W-1:0] disp_src1_tag,
  input  logic                disp_src1_rdy,
  input  logic [RS_SEQ_W-1:0] disp_seq,
  input  logic                bcast_valid,
  input  logic [RS_TAG_W-1:0] bcast_tag,
  input  logic                flush_valid,
  input  logic [RS_SEQ_W-1:0] flush_seq,
  output logic                iss_valid,
  input  logic                iss_ready,
  output logic [RS_PAY_W-1:0] iss_payload,
  output logic [RS_TAG_W-1:0] iss_dst_tag,
  output logic [RS_TAG_W-1:0] iss_src0_tag,
  output logic [RS_TAG_W-1:0] iss_src1_tag,
  output logic [RS_SEQ_W-1:0] iss_seq
);
  localparam int N = NUM_ENTRIES;

  rs_uop_t      din;
  rs_uop_t      ent_vec [N];
  logic [N-1:0] valid_vec;
  logic [N-1:0] ready_vec;
  logic [N-1:0] pick_oh;
  logic [N-1:0] alloc_oh;
  logic [N-1:0] gnt;
  logic [N-1:0] kill_vec;
  logic         any_free;
  logic         disp_fire;
  logic         iss_fire;

  always_comb begin
    din            = '0;
    din.payload    = disp_payload;
    din.dst        = disp_dst_tag;
    din.seq        = disp_seq;
    din.src_tag[0] = disp_src0_tag;
    din.src_tag[1] = disp_src1_tag;
    din.src_rdy[0] = disp_src0_rdy;
    din.src_rdy[1] = disp_src1_rdy;
  end

  rs_free_pick #(.N(N)) u_pick (
    .busy     (valid_vec),
    .pick_oh  (pick_oh),
    .any_free (any_free)
  );

  assign disp_ready = any_free && !flush_valid;
  assign disp_fire  = disp_valid && disp_ready;
  assign alloc_oh   = pick_oh & {N{disp_fire}};

  rs_age_matrix #(.N(N)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_oh (alloc_oh),
    .req      (ready_vec),
    .gnt      (gnt)
  );

  assign iss_valid = (|ready_vec) && !flush_valid;
  assign iss_fire  = iss_valid && iss_ready;
  assign kill_vec  = gnt & {N{iss_fire}};

  generate
    for (genvar i = 0; i < N; i++) begin : g_ent
      rs_entry u_ent (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc       (alloc_oh[i]),
        .din         (din),
        .bcast_valid (bcast_valid),
        .bcast_tag   (bcast_tag),
        .issue_kill  (kill_vec[i]),
        .flush_valid (flush_valid),
        .flush_seq   (flush_seq),
        .valid       (valid_vec[i]),
        .ready       (ready_vec[i]),
        .dout        (ent_vec[i])
      );
    end
  endgenerate

  // AND-OR issue multiplexer driven by the one-hot grant
  always_comb begin
    iss_payload  = '0;
    iss_dst_tag  = '0;
    iss_src0_tag = '0;
    iss_src1_tag = '0;
    iss_seq      = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) begin
        iss_payload  = iss_payload  | ent_vec[i].payload;
        iss_dst_tag  = iss_dst_tag  | ent_vec[i].dst;
        iss_src0_tag = iss_src0_tag | ent_vec[i].src_tag[0];
        iss_src1_tag = iss_src1_tag | ent_vec[i].src_tag[1];
        iss_seq      = iss_seq      | ent_vec[i].seq;
      end
    end
  end

  // ---------------- checker logic ----------------
  logic                older_ready_exists;
  logic                flush_q;
  logic [RS_SEQ_W-1:0] flush_seq_q;
  logic                survivor_bad;

  always_comb begin
    older_ready_exists = 1'b0;
    survivor_bad       = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ready_vec[i] && seq_younger(iss_seq, ent_vec[i].seq)) older_ready_exists = 1'b1;
      if (valid_vec[i] && seq_younger(ent_vec[i].seq, flush_seq_q)) survivor_bad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q     <= 1'b0;
      flush_seq_q <= '0;
    end else begin
      flush_q     <= flush_valid;
      flush_seq_q <= flush_seq;
    end
  end

  AST_OLDEST_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !older_ready_exists); // R5

  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> !survivor_bad); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> ($countones(valid_vec) ==
                   $past($countones(valid_vec)) + 1 - ($past(iss_fire) ? 1 : 0))); // R7

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !bcast_valid) |=>
      (flush_valid || (iss_valid && iss_seq == $past(iss_seq)))); // R6
endmodule

// File: tb/tb_rs_wakeup_select.sv
`timescale 1ns/1ps
module tb_rs_wakeup_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic        disp_ready;
  logic [15:0] disp_payload = '0;
  logic [5:0]  disp_dst_tag = '0;
  logic [5:0]  disp_src0_tag = '0;
  logic        disp_src0_rdy = 1'b0;
  logic [5:0]  disp_src1_tag = '0;
  logic        disp_src1_rdy = 1'b0;
  logic [5:0]  disp_seq = '0;
  logic        bcast_valid = 1'b0;
  logic [5:0]  bcast_tag = '0;
  logic        flush_valid = 1'b0;
  logic [5:0]  flush_seq = '0;
  logic        iss_valid;
  logic        iss_ready = 1'b0;
  logic [15:0] iss_payload;
  logic [5:0]  iss_dst_tag;
  logic [5:0]  iss_src0_tag;
  logic [5:0]  iss_src1_tag;
  logic [5:0]  iss_seq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rs_wakeup_select dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_payload(disp_payload),
    .disp_dst_tag(disp_dst_tag), .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
    .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy), .disp_seq(disp_seq),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
    .flush_valid(flush_valid), .flush_seq(flush_seq),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_payload(iss_payload),
    .iss_dst_tag(iss_dst_tag), .iss_src0_tag(iss_src0_tag), .iss_src1_tag(iss_src1_tag),
    .iss_seq(iss_seq)
  );

  // scoreboard queue of pending micro-ops
  bit       q_v   [8];
  bit [5:0] q_seq [8];
  bit [15:0] q_pay[8];
  bit [5:0] q_t   [8][2];
  bit       q_r   [8][2];
  bit [5:0] nseq = 6'd0;

  function automatic bit yng(input bit [5:0] a, input bit [5:0] b);
    bit [5:0] d;
    d = a - b;
    return (d != 0) && (d < 6'd32);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic int occupancy();
    int c = 0;
    for (int k = 0; k < 8; k++) if (q_v[k]) c++;
    return c;
  endfunction

  function automatic int oldest_ready();
    int b = -1;
    for (int k = 0; k < 8; k++)
      if (q_v[k] && q_r[k][0] && q_r[k][1])
        if (b < 0 || yng(q_seq[b], q_seq[k])) b = k;
    return b;
  endfunction

  // monitor + scoreboard update for one cycle; inputs already driven
  task automatic tick(input string req);
    int  b;
    bit  exp_dr, exp_iv, acc;
    #1;
    b      = oldest_ready();
    exp_dr = (occupancy() < 8) && !flush_valid;
    exp_iv = (b >= 0) && !flush_valid;
    check(req, "disp_ready", 32'(disp_ready), 32'(exp_dr));
    check(req, "iss_valid", 32'(iss_valid), 32'(exp_iv));
    if (exp_iv && iss_valid) begin
      check(req, "iss_seq", 32'(iss_seq), 32'(q_seq[b]));
      check(req, "iss_payload", 32'(iss_payload), 32'(q_pay[b]));
    end
    if (exp_iv && iss_ready) q_v[b] = 0;
    if (flush_valid)
      for (int k = 0; k < 8; k++) if (q_v[k] && yng(q_seq[k], flush_seq)) q_v[k] = 0;
    if (bcast_valid)
      for (int k = 0; k < 8; k++)
        for (int s = 0; s < 2; s++) if (q_v[k] && q_t[k][s] == bcast_tag) q_r[k][s] = 1;
    acc = disp_valid && exp_dr;
    if (acc) begin
      for (int k = 0; k < 8; k++) begin
        if (!q_v[k]) begin
          q_v[k] = 1; q_seq[k] = disp_seq; q_pay[k] = disp_payload;
          q_t[k][0] = disp_src0_tag; q_t[k][1] = disp_src1_tag;
          q_r[k][0] = disp_src0_rdy || (bcast_valid && disp_src0_tag == bcast_tag);
          q_r[k][1] = disp_src1_rdy || (bcast_valid && disp_src1_tag == bcast_tag);
          break;
        end
      end
    end
    @(posedge clk);
    if (acc) nseq = nseq + 6'd1;
    @(negedge clk);
  endtask

  task automatic idle();
    disp_valid = 0; bcast_valid = 0; flush_valid = 0;
  endtask

  // driver: present one micro-op on the dispatch stream
  task automatic put(input bit [5:0] t0, input bit r0, input bit [5:0] t1, input bit r1);
    disp_valid = 1; disp_seq = nseq; disp_payload = {nseq, 4'h5, nseq ^ 6'h2A};
    disp_dst_tag = nseq; disp_src0_tag = t0; disp_src0_rdy = r0;
    disp_src1_tag = t1; disp_src1_rdy = r1;
  endtask

  task automatic bc(input bit [5:0] t);
    bcast_valid = 1; bcast_tag = t;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    idle(); tick("R1");

    // R2: ready at dispatch, eligible only after the edge
    put(6'd1, 1, 6'd2, 1); tick("R2");
    idle(); tick("R2"); tick("R6");
    iss_ready = 1; tick("R6");
    iss_ready = 0; tick("R6");

    // R9 / R3: one source waiting, unrelated then matching broadcast
    put(6'd3, 1, 6'd5, 0); tick("R9");
    idle(); tick("R9");
    bc(6'd7); tick("R3");
    bc(6'd5); tick("R3");
    idle(); tick("R3");
    iss_ready = 1; tick("R3"); iss_ready = 0;
    put(6'd10, 0, 6'd11, 0); tick("R9");
    idle(); bc(6'd10); tick("R9");
    idle(); tick("R9");
    bc(6'd11); tick("R3");
    idle(); tick("R3");
    iss_ready = 1; tick("R6"); iss_ready = 0;

    // R4: same-cycle wakeup capture
    put(6'd9, 0, 6'd2, 1); bc(6'd9); tick("R4");
    idle(); tick("R4");
    iss_ready = 1; tick("R4"); iss_ready = 0; tick("R4");

    // R5: wrap-around and slot reuse
    nseq = 6'd60;
    put(6'd20, 0, 6'd1, 1); tick("R5");
    put(6'd1, 1, 6'd1, 1);  tick("R5");
    put(6'd1, 1, 6'd1, 1);  tick("R5");
    put(6'd21, 0, 6'd1, 1); tick("R5");
    put(6'd1, 1, 6'd1, 1);  tick("R5");
    idle(); tick("R5"); tick("R6");
    iss_ready = 1; tick("R5"); iss_ready = 0;
    put(6'd1, 1, 6'd1, 1); tick("R5");
    idle(); bc(6'd20); tick("R5");
    idle(); tick("R5");
    iss_ready = 1; tick("R5"); tick("R5"); iss_ready = 0;
    bc(6'd21); tick("R5");
    idle(); iss_ready = 1;
    repeat (4) tick("R5");
    iss_ready = 0;

    // R7: fill, reject ninth, drain oldest-first
    for (int k = 0; k < 8; k++) begin put(6'd30, 0, 6'd31, 1); tick("R7"); end
    put(6'd1, 1, 6'd1, 1); tick("R7");
    idle(); tick("R7");
    bc(6'd30); tick("R7");
    idle(); iss_ready = 1;
    repeat (9) tick("R7");
    iss_ready = 0;

    // R8: flush with mixed ages, one ready entry present
    put(6'd2, 1, 6'd2, 1); tick("R8");
    for (int k = 0; k < 4; k++) begin put(6'd40, 0, 6'd1, 1); tick("R8"); end
    idle(); flush_valid = 1; flush_seq = nseq - 6'd3; tick("R8");
    idle(); tick("R8");
    bc(6'd40); tick("R8");
    idle(); iss_ready = 1;
    repeat (5) tick("R8");
    iss_ready = 0;

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int oldest_gap;
      idle();
      oldest_gap = 0;
      for (int k = 0; k < 8; k++)
        if (q_v[k] && int'(6'(nseq - q_seq[k])) > oldest_gap) oldest_gap = int'(6'(nseq - q_seq[k]));
      if (($urandom % 100) < 55 && oldest_gap < 20)
        put(6'($urandom % 16), 1'($urandom % 2), 6'($urandom % 16), 1'($urandom % 2));
      if (($urandom % 100) < 50) bc(6'($urandom % 16));
      if (($urandom % 100) < 3) begin flush_valid = 1; flush_seq = nseq - 6'd1 - 6'($urandom % 6); end
      iss_ready = (($urandom % 100) < 60);
      tick("R5");
    end
    idle(); iss_ready = 0;
    finish_run();
  end
endmodule